// File: doc/BRIEF.md
# Counter-Indexed Serial Channel Link

This block carries a bank of parallel data channels over one serial bit and rebuilds them at the far end. A single index counter names the channel that is current. The send side uses that index to pick one bit of the parallel input and place it on the serial line. The receive side decodes the same index into a set of active-low write strobes, and the one strobe that is low loads the serial bit into that channel's receive register. Because both ends follow one index, the sender and the receiver always work on the same channel.

Two mode inputs control the index. It can step up, step down or stay put, and both inputs low sends it back to channel zero. Each step wraps around the channel count. The receive strobes come from a row of 3-to-8 decoders with active-low outputs. The top index bits choose which decoder is enabled. A separate active-high inhibit input disables every decoder, which freezes all receive registers for that cycle. The index is also driven out as a select bus, so a remote unit can follow it.

Top module: `serial_chan_link`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, `sel_idx` becomes 0 and every bit of `rx_data` becomes 0 after that edge.
- R2: With `rst_n` high and mode code {`mode_s1`,`mode_s0`} = 2'b00 at a rising edge, `sel_idx` is 0 after that edge, whatever its earlier value.
- R3: Mode code 2'b01 adds one to `sel_idx` at each rising edge, and 15 wraps to 0.
- R4: Mode code 2'b10 subtracts one from `sel_idx` at each rising edge, and 0 wraps to 15.
- R5: Mode code 2'b11 leaves `sel_idx` unchanged across the edge.
- R6: `ser_line` always equals `tx_data[sel_idx]`, with no clock delay.
- R7: When `rx_hold` is low, exactly one strobe is low: `strobe_n[sel_idx]`. Strobes 0 to 7 come from the lower decoder and 8 to 15 from the upper one. Index bit 3 chooses the decoder, and bits 2:0 form its address, with bit 0 the least significant.
- R8: When `rx_hold` is high, every bit of `strobe_n` is high, and no bit of `rx_data` changes at the next edge.
- R9: At a rising edge with `rst_n` high, the receive register whose strobe is low loads `ser_line`. Every other bit of `rx_data` keeps its value. This also holds in the reset-mode cycle, where the capture uses the index that was current before it returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_s0 | input | 1 | Index mode code, low bit |
| mode_s1 | input | 1 | Index mode code, high bit |
| rx_hold | input | 1 | Active-high disable for all receive strobes |
| tx_data | input | 16 | Parallel send channels |
| ser_line | output | 1 | Serial bit, the send channel named by the index |
| sel_idx | output | 4 | Current channel index (select bus) |
| strobe_n | output | 16 | Active-low receive write strobes |
| rx_data | output | 16 | Rebuilt receive channels |

## Verification
The hardest case to reach from the ports is a capture that happens during an index wrap or a reset-mode cycle. In those cycles the register that loads is chosen by the old index, which sits at the edge of one decoder, while the index itself jumps to the other decoder. The stimulus builds long runs of steps up and down to cross 15/0 in both directions. It then mixes in reset-mode codes at non-zero indices and random bursts of `rx_hold`. The random `tx_data` changes every cycle, so a capture that uses the wrong index or the wrong cycle writes a value the model does not expect.

// File: rtl/serial_chan_link_pkg.sv
// Package: shared mode encoding for the serial channel link.
// Assumes the mode code is formed as {s1, s0}.
package serial_chan_link_pkg;

    typedef enum logic [1:0] {
        MD_CLEAR = 2'b00,
        MD_UP    = 2'b01,
        MD_DOWN  = 2'b10,
        MD_KEEP  = 2'b11
    } idx_mode_e;

    localparam int unsigned SUB_ADDR_W = 3;  // address width of one line decoder

endpackage

// File: rtl/chan_index_counter.sv
// Module: chan_index_counter
// Holds the shared channel index. It steps up, steps down, holds or clears,
// as the mode code selects, and wraps modulo 2**IDX_W.
// Assumes: the reset is synchronous and active low.
module chan_index_counter
    import serial_chan_link_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  idx_mode_e        mode,
    output logic [IDX_W-1:0] cnt
);

    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    // Purpose: next-index register with a synchronous clear and modular stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (mode)
                MD_CLEAR: cnt <= '0;
                MD_UP:    cnt <= cnt + ONE;
                MD_DOWN:  cnt <= cnt - ONE;
                MD_KEEP:  cnt <= cnt;
                default:  cnt <= cnt;
            endcase
        end
    end

    AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_CLEAR) |=> (cnt == '0));                                     // R2
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_UP) |=> (cnt == $past(cnt) + ONE));                         // R3
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_DOWN) |=> (cnt == $past(cnt) - ONE));                       // R4
    AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_KEEP) |=> $stable(cnt));                                    // R5

endmodule

// File: rtl/chan_tx_mux.sv
// Module: chan_tx_mux
// Send-side selector. It places the send channel that the index names on the
// serial line, with no register in the path.
// Assumes: NCH equals 2**IDX_W.
module chan_tx_mux #(
    parameter int unsigned NCH   = 16,
    parameter int unsigned IDX_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]   data,
    input  logic [IDX_W-1:0] sel,
    output logic             ser
);

    // Purpose: combinational N:1 bit select.
    always_comb begin
        ser = data[sel];
    end

endmodule

// File: rtl/line_decoder.sv
// Module: line_decoder
// Binary-to-one-of-N decoder with active-low outputs. The addressed line goes
// low and every other line stays high. If either disable input is high, all
// lines are high.
// Assumes: addr bit 0 has the lowest weight.
module line_decoder #(
    parameter int unsigned ADDR_W = 3,
    localparam int unsigned LINES = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dis_a,
    input  logic              dis_b,
    output logic [LINES-1:0]  lines_n
);

    // Purpose: parallel decode, with one compare per output line.
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            lines_n[i] = dis_a | dis_b | (addr != ADDR_W'(i));
        end
    end

endmodule

// File: rtl/chan_rx_demux.sv
// Module: chan_rx_demux
// Receive side. The upper index bits enable one of several line decoders,
// and that decoder turns the low index bits into one active-low strobe.
// A low strobe loads the serial bit into its receive register.
// Assumes: NCH is a power of two, and at least twice the decoder width.
module chan_rx_demux
    import serial_chan_link_pkg::*;
#(
    parameter int unsigned NCH   = 16,
    parameter int unsigned IDX_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] sel,
    input  logic             ser,
    input  logic             hold,
    output logic [NCH-1:0]   strobe_n,
    output logic [NCH-1:0]   rx_q
);

    localparam int unsigned SUB_W = SUB_ADDR_W;
    localparam int unsigned SUB_N = 1 << SUB_W;
    localparam int unsigned NDEC  = NCH / SUB_N;
    localparam int unsigned HI_W  = IDX_W - SUB_W;

    logic [HI_W-1:0] sel_hi;
    logic [SUB_W-1:0] sel_lo;

    // Purpose: split the index into a decoder choice and a line address.
    always_comb begin
        sel_hi = sel[IDX_W-1:SUB_W];
        sel_lo = sel[SUB_W-1:0];
    end

    for (genvar g = 0; g < NDEC; g++) begin : g_dec
        logic off_bank;
        // Purpose: disable this decoder unless the upper index bits name it.
        always_comb begin
            off_bank = (sel_hi != HI_W'(g));
        end
        line_decoder #(.ADDR_W(SUB_W)) u_dec (
            .addr    (sel_lo),
            .dis_a   (hold),
            .dis_b   (off_bank),
            .lines_n (strobe_n[g*SUB_N +: SUB_N])
        );
    end

    for (genvar k = 0; k < NCH; k++) begin : g_reg
        // Purpose: receive register k, loaded while its strobe is low.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rx_q[k] <= 1'b0;
            end else if (!strobe_n[k]) begin
                rx_q[k] <= ser;
            end
        end
    end

    AST_STROBE_AT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> ($onehot0(~strobe_n) && !strobe_n[sel]));                     // R7
    AST_HOLD_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (&strobe_n));                                                  // R8
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(rx_q));                                                // R8
    AST_CAPTURE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> (rx_q[$past(sel)] == $past(ser)));                            // R9

endmodule

// File: rtl/serial_chan_link.sv
// Module: serial_chan_link (top)
// Shared-index serial link. A single counter drives both the send selector
// and the receive decoders, so the two ends name the same channel.
// Assumes: a single clock and a synchronous active-low reset.
module serial_chan_link
    import serial_chan_link_pkg::*;
#(
    parameter int unsigned NCH   = 16,
    localparam int unsigned IDX_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_s0,
    input  logic             mode_s1,
    input  logic             rx_hold,
    input  logic [NCH-1:0]   tx_data,
    output logic             ser_line,
    output logic [IDX_W-1:0] sel_idx,
    output logic [NCH-1:0]   strobe_n,
    output logic [NCH-1:0]   rx_data
);

    idx_mode_e mode;

    // Purpose: form the mode code from the two pins.
    always_comb begin
        mode = idx_mode_e'({mode_s1, mode_s0});
    end

    chan_index_counter #(.IDX_W(IDX_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .cnt   (sel_idx)
    );

    chan_tx_mux #(.NCH(NCH), .IDX_W(IDX_W)) u_mux (
        .data (tx_data),
        .sel  (sel_idx),
        .ser  (ser_line)
    );

    chan_rx_demux #(.NCH(NCH), .IDX_W(IDX_W)) u_dmx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel_idx),
        .ser      (ser_line),
        .hold     (rx_hold),
        .strobe_n (strobe_n),
        .rx_q     (rx_data)
    );

    AST_SER_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        ser_line == tx_data[sel_idx]);                                          // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (sel_idx == '0 && rx_data == '0));                           // R1

endmodule

// File: tb/serial_chan_link_tb.sv
module serial_chan_link_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_s0 = 1'b0;
    logic        mode_s1 = 1'b0;
    logic        rx_hold = 1'b0;
    logic [15:0] tx_data = '0;
    logic        ser_line;
    logic [3:0]  sel_idx;
    logic [15:0] strobe_n;
    logic [15:0] rx_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int          m_idx = 0;
    logic [15:0] m_rx = '0;
    string       idx_tag = "R1";
    string       rx_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_chan_link u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_s0  (mode_s0),
        .mode_s1  (mode_s1),
        .rx_hold  (rx_hold),
        .tx_data  (tx_data),
        .ser_line (ser_line),
        .sel_idx  (sel_idx),
        .strobe_n (strobe_n),
        .rx_data  (rx_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check, then advance the model at the rising edge.
    task automatic step(input logic rst, input logic [1:0] md, input logic hold,
                        input logic [15:0] d);
        logic [15:0] exp_strobe;
        @(negedge clk);
        rst_n = rst; mode_s1 = md[1]; mode_s0 = md[0]; rx_hold = hold; tx_data = d;
        #1;
        chk(sel_idx == 4'(m_idx), idx_tag, "sel_idx", 32'(sel_idx), 32'(m_idx));
        chk(rx_data == m_rx, rx_tag, "rx_data", 32'(rx_data), 32'(m_rx));
        chk(ser_line == d[m_idx], "R6", "ser_line", 32'(ser_line), 32'(d[m_idx]));
        exp_strobe = hold ? 16'hFFFF : ~(16'h1 << m_idx);
        chk(strobe_n == exp_strobe, hold ? "R8" : "R7", "strobe_n",
            32'(strobe_n), 32'(exp_strobe));
        @(posedge clk);
        if (!rst) begin
            m_idx = 0; m_rx = '0; idx_tag = "R1"; rx_tag = "R1";
        end else begin
            if (!hold) begin
                m_rx[m_idx] = d[m_idx]; rx_tag = "R9";
            end else begin
                rx_tag = "R8";
            end
            case (md)
                2'b00: begin m_idx = 0; idx_tag = "R2"; end
                2'b01: begin m_idx = (m_idx + 1) % 16; idx_tag = "R3"; end
                2'b10: begin m_idx = (m_idx + 15) % 16; idx_tag = "R4"; end
                default: idx_tag = "R5";
            endcase
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(1'b0, 2'b01, 1'b0, 16'hA5A5);
        step(1'b0, 2'b01, 1'b0, 16'h5A5A);
        // R3: step up across the 15 -> 0 wrap
        for (int i = 0; i < 20; i++) step(1'b1, 2'b01, 1'b0, 16'($urandom));
        // R5: hold with changing data
        for (int i = 0; i < 6; i++) step(1'b1, 2'b11, 1'b0, 16'($urandom));
        // R2: clear from a non-zero index
        step(1'b1, 2'b00, 1'b0, 16'hFFFF);
        // R4: step down across the 0 -> 15 wrap
        for (int i = 0; i < 20; i++) step(1'b1, 2'b10, 1'b0, 16'($urandom));
        // R8: inhibit while stepping
        for (int i = 0; i < 8; i++) step(1'b1, 2'b01, 1'b1, 16'($urandom));
        // Mixed modes, inhibit and clears
        for (int i = 0; i < 300; i++)
            step(1'b1, 2'($urandom), ($urandom % 4) == 0, 16'($urandom));
        // R1: reset in mid-run, then recover
        step(1'b0, 2'b11, 1'b0, 16'hFFFF);
        for (int i = 0; i < 4; i++) step(1'b1, 2'b10, 1'b0, 16'($urandom));
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule